// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Manager

This block takes a DRAM from normal operation into self refresh when a system low-power request rises, and brings it back when the request falls. While it works it owns the row and column strobes, which it drives active low; the normal memory controller has them at all other times. Entry is a column-before-row strobe sequence. The row strobe is then held low for at least the minimum self-refresh pulse width, counted in clock cycles. Exit raises the column strobe first. The row strobe then rises, followed by the long self-refresh precharge.

A guard CBR refresh runs just before each entry and again just after each exit. A row-coverage counter counts completed refreshes reported by the normal refresh engine while the block is idle. The counter clears on every exit, and the block holds back a new entry until the count reaches the full row count. A wake request seen during the minimum hold is remembered. Exit then starts on the first cycle after the hold expires. So the row strobe is never low for a time inside the device's unstable mode-change window.

Top module: `selfrefresh_mgr`

## Requirements
- R1: While reset is high and on the first cycle after it, ras_n and cas_n are 1 and sleep_ack and strobe_own are 0. The coverage count starts at zero.
- R2: In idle, with coverage below ROWS, sleep_req is ignored. The strobes stay high and strobe_own stays 0. Each refresh_tick pulse seen in idle adds one to coverage, saturating at ROWS.
- R3: On sleep_req with full coverage, a guard CBR refresh runs first. cas_n goes low for CSR_CYC cycles. Both strobes are then low for RAS_CYC cycles. Both are then high for RP_CYC cycles.
- R4: Entry drives cas_n low for CSR_CYC cycles with ras_n high. Both strobes then go low together with sleep_ack. They stay low for at least HOLD_CYC cycles, and for as long as sleep_req stays high.
- R5: If sleep_req is low on any cycle of the HOLD_CYC hold, the wake is remembered even if sleep_req rises again. Exit starts right after the hold, so sleep_ack is high for exactly HOLD_CYC cycles.
- R6: Exit raises cas_n and drops sleep_ack for CHS_CYC cycles while ras_n stays low.
- R7: After ras_n rises at exit, both strobes stay high for RPS_CYC cycles. A guard CBR refresh with the R3 shape follows, and then the block returns to idle.
- R8: Coverage clears at exit and the post-exit guard counts as one refresh. refresh_tick outside idle is ignored. A new entry needs ROWS-1 further idle ticks.
- R9: Every low period of ras_n lasts either at most RAS_CYC cycles or at least HOLD_CYC cycles.
- R10: strobe_own is 1 whenever ras_n or cas_n is low, and through every precharge the block times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Low-power request level |
| refresh_tick | input | 1 | One-cycle pulse per completed normal refresh |
| sleep_ack | output | 1 | High while the device is held in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| strobe_own | output | 1 | Block owns the strobes |

## Verification
The bench goes after the coverage boundary, with a request at ROWS-1 refreshes and again at ROWS. A design with an off-by-one in the counter would either enter too early or hang. It drops and re-raises sleep_req inside the hold: a design that forgets the wake would stay asleep, and one that acts on it at once would cut the hold short into the forbidden window. It pulses refresh_tick during sleep. A design that counts those ticks would allow re-entry before all rows are covered again. The bench also measures every row-strobe low period, the exit precharge length, and the column-first exit order.

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GCAS,
        ST_GRAS,
        ST_GPRE,
        ST_ECAS,
        ST_HOLD,
        ST_SLEEP,
        ST_XCAS,
        ST_XPRE
    } srm_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic ack;
        logic own;
    } srm_pins_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic srm_pins_t pins_for(srm_state_e s);
        srm_pins_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, ack: 1'b0, own: 1'b1};
        case (s)
            ST_IDLE:  p.own = 1'b0;
            ST_GCAS,
            ST_ECAS:  p.cas_n = 1'b0;
            ST_GRAS:  begin p.ras_n = 1'b0; p.cas_n = 1'b0; end
            ST_HOLD,
            ST_SLEEP: begin p.ras_n = 1'b0; p.cas_n = 1'b0; p.ack = 1'b1; end
            ST_XCAS:  p.ras_n = 1'b0;
            default:  ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/srm_coverage.sv
module srm_coverage #(
    parameter int ROWS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic in_idle,
    input  logic guard_done,
    input  logic clear,
    output logic full
);
    localparam int CW = $clog2(ROWS + 1);

    logic [CW-1:0] count;
    logic          bump;

    assign full = (count == CW'(ROWS));
    assign bump = (in_idle && tick) || guard_done;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (bump && !full)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/srm_sequencer.sv
module srm_sequencer
    import srm_pkg::*;
#(
    parameter int CSR_CYC  = 1,
    parameter int RAS_CYC  = 6,
    parameter int RP_CYC   = 4,
    parameter int HOLD_CYC = 10000,
    parameter int CHS_CYC  = 1,
    parameter int RPS_CYC  = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       cov_full,
    output srm_state_e state,
    output logic       exit_go,
    output logic       guard_done
);
    localparam int unsigned MAXD = max2(max2(HOLD_CYC, RPS_CYC),
                                        max2(max2(RAS_CYC, RP_CYC), max2(CSR_CYC, CHS_CYC)));
    localparam int TW = $clog2(MAXD + 1);

    srm_state_e    nxt;
    logic [TW-1:0] cnt;
    logic [TW-1:0] ld_val;
    logic          load;
    logic          post;
    logic          wake;
    logic          done;

    assign done = (cnt == '0);

    always_comb begin
        nxt        = state;
        load       = 1'b0;
        ld_val     = '0;
        exit_go    = 1'b0;
        guard_done = 1'b0;
        case (state)
            ST_IDLE: if (sleep_req && cov_full) begin
                nxt = ST_GCAS; load = 1'b1; ld_val = TW'(CSR_CYC - 1);
            end
            ST_GCAS: if (done) begin
                nxt = ST_GRAS; load = 1'b1; ld_val = TW'(RAS_CYC - 1);
            end
            ST_GRAS: if (done) begin
                nxt = ST_GPRE; load = 1'b1; ld_val = TW'(RP_CYC - 1);
            end
            ST_GPRE: if (done) begin
                if (post) begin
                    nxt = ST_IDLE; guard_done = 1'b1;
                end else begin
                    nxt = ST_ECAS; load = 1'b1; ld_val = TW'(CSR_CYC - 1);
                end
            end
            ST_ECAS: if (done) begin
                nxt = ST_HOLD; load = 1'b1; ld_val = TW'(HOLD_CYC - 1);
            end
            ST_HOLD: if (done) begin
                if (wake || !sleep_req) begin
                    nxt = ST_XCAS; load = 1'b1; ld_val = TW'(CHS_CYC - 1); exit_go = 1'b1;
                end else begin
                    nxt = ST_SLEEP;
                end
            end
            ST_SLEEP: if (!sleep_req) begin
                nxt = ST_XCAS; load = 1'b1; ld_val = TW'(CHS_CYC - 1); exit_go = 1'b1;
            end
            ST_XCAS: if (done) begin
                nxt = ST_XPRE; load = 1'b1; ld_val = TW'(RPS_CYC - 1);
            end
            ST_XPRE: if (done) begin
                nxt = ST_GCAS; load = 1'b1; ld_val = TW'(CSR_CYC - 1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            post  <= 1'b0;
            wake  <= 1'b0;
        end else begin
            state <= nxt;
            if (load)
                cnt <= ld_val;
            else if (!done)
                cnt <= cnt - 1'b1;
            if (state == ST_XPRE && done)
                post <= 1'b1;
            else if (guard_done)
                post <= 1'b0;
            if (state == ST_HOLD)
                wake <= wake || !sleep_req;
            else
                wake <= 1'b0;
        end
    end
endmodule

// File: rtl/srm_strobe_decode.sv
module srm_strobe_decode
    import srm_pkg::*;
(
    input  srm_state_e state,
    output srm_pins_t  pins
);
    assign pins = pins_for(state);
endmodule

// File: rtl/selfrefresh_mgr.sv
module selfrefresh_mgr
    import srm_pkg::*;
#(
    parameter int ROWS     = 1024,
    parameter int CSR_CYC  = 1,
    parameter int RAS_CYC  = 6,
    parameter int RP_CYC   = 4,
    parameter int HOLD_CYC = 10000,
    parameter int CHS_CYC  = 1,
    parameter int RPS_CYC  = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic refresh_tick,
    output logic sleep_ack,
    output logic ras_n,
    output logic cas_n,
    output logic strobe_own
);
    srm_state_e state;
    srm_pins_t  pins;
    logic       cov_full;
    logic       exit_go;
    logic       guard_done;

    srm_sequencer #(
        .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
        .HOLD_CYC(HOLD_CYC), .CHS_CYC(CHS_CYC), .RPS_CYC(RPS_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .cov_full(cov_full),
        .state(state), .exit_go(exit_go), .guard_done(guard_done)
    );

    srm_coverage #(.ROWS(ROWS)) u_cov (
        .clk(clk), .rst(rst), .tick(refresh_tick),
        .in_idle(state == ST_IDLE), .guard_done(guard_done),
        .clear(exit_go), .full(cov_full)
    );

    srm_strobe_decode u_dec (.state(state), .pins(pins));

    assign ras_n      = pins.ras_n;
    assign cas_n      = pins.cas_n;
    assign sleep_ack  = pins.ack;
    assign strobe_own = pins.own;
endmodule

// File: rtl/selfrefresh_mgr_chk.sv
module selfrefresh_mgr_chk #(
    parameter int RAS_CYC  = 6,
    parameter int HOLD_CYC = 10000,
    parameter int RPS_CYC  = 11
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic sleep_ack,
    input logic strobe_own
);
    int unsigned low_len;
    int unsigned hi_len;
    logic        after_long;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_len    <= 0;
            hi_len     <= 0;
            after_long <= 1'b0;
        end else begin
            low_len <= ras_n ? 0 : low_len + 1;
            hi_len  <= ras_n ? hi_len + 1 : 0;
            if (!ras_n)
                after_long <= 1'b0;
            else if (low_len >= HOLD_CYC)
                after_long <= 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && !sleep_ack && !strobe_own));

    // R4
    entry_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_ack) |-> (!ras_n && !cas_n && $past(ras_n && !cas_n)));

    // R6
    exit_cas_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_ack) |-> (cas_n && !ras_n));

    // R7
    exit_precharge_chk: assert property (@(posedge clk) disable iff (rst)
        (after_long && $fell(cas_n)) |-> (hi_len >= RPS_CYC));

    // R9
    no_window_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n && low_len != 0) |-> (low_len <= RAS_CYC || low_len >= HOLD_CYC));

    // R10
    own_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> strobe_own);
endmodule

bind selfrefresh_mgr selfrefresh_mgr_chk #(
    .RAS_CYC(RAS_CYC), .HOLD_CYC(HOLD_CYC), .RPS_CYC(RPS_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n),
    .sleep_ack(sleep_ack), .strobe_own(strobe_own)
);

// File: tb/selfrefresh_mgr_bench.sv
module selfrefresh_mgr_bench;
    localparam int ROWS = 1024, CSR = 1, RASC = 6, RP = 4, HOLD = 10000, CHS = 1, RPS = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic refresh_tick = 1'b0;
    logic sleep_ack, ras_n, cas_n, strobe_own;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;

    always #5 clk = ~clk;

    selfrefresh_mgr #(
        .ROWS(ROWS), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP),
        .HOLD_CYC(HOLD), .CHS_CYC(CHS), .RPS_CYC(RPS)
    ) u_selfrefresh_mgr (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .refresh_tick(refresh_tick),
        .sleep_ack(sleep_ack), .ras_n(ras_n), .cas_n(cas_n), .strobe_own(strobe_own)
    );

    typedef struct { bit r; bit c; bit a; bit o; string tag; } ent_t;
    ent_t q[$];
    ent_t exp_e = '{1'b1, 1'b1, 1'b0, 1'b0, "R1"};
    int   cov = 0;
    bit   wake = 0;

    task automatic push(bit r, bit c, bit a, bit o, string tag, int n);
        for (int i = 0; i < n; i++) q.push_back('{r, c, a, o, tag});
    endtask

    task automatic push_guard(string tag);
        push(1, 0, 0, 1, tag, CSR);
        push(0, 0, 0, 1, tag, RASC);
        push(1, 1, 0, 1, tag, RP);
    endtask

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            q.delete(); cov = 0; wake = 0;
            exp_e = '{1'b1, 1'b1, 1'b0, 1'b0, "R1"};
        end else if (q.size() > 0) begin
            if (exp_e.a && !sleep_req) wake = 1;
            exp_e = q.pop_front();
        end else if (!exp_e.o) begin
            if (sleep_req && cov == ROWS) begin
                push_guard("R3");
                push(1, 0, 0, 1, "R4", CSR);
                push(0, 0, 1, 1, "R4", HOLD);
                exp_e = q.pop_front();
            end else begin
                if (refresh_tick && cov < ROWS) cov++;
                exp_e = '{1'b1, 1'b1, 1'b0, 1'b0, "R2"};
            end
        end else if (exp_e.a) begin
            if (!sleep_req || wake) begin
                push(0, 1, 0, 1, "R6", CHS);
                push(1, 1, 0, 1, "R7", RPS);
                push_guard("R7");
                cov = 0; wake = 0;
                exp_e = q.pop_front();
            end
        end else begin
            cov++;
            exp_e = '{1'b1, 1'b1, 1'b0, 1'b0, "R8"};
        end
    end

    int ack_run = 0, last_ack = 0, low_run = 0;

    always @(negedge clk) begin
        cycles++;
        if (started && !rst) begin
            check({ras_n, cas_n, sleep_ack, strobe_own} == {exp_e.r, exp_e.c, exp_e.a, exp_e.o},
                  exp_e.tag, {ras_n, cas_n, sleep_ack, strobe_own},
                  {exp_e.r, exp_e.c, exp_e.a, exp_e.o});
            if (!strobe_own && (!ras_n || !cas_n))
                check(0, "R10", strobe_own, 1);
            if (sleep_ack) ack_run++;
            else if (ack_run > 0) begin last_ack = ack_run; ack_run = 0; end
            if (!ras_n) low_run++;
            else if (low_run > 0) begin
                check(low_run <= RASC || low_run >= HOLD, "R9", low_run, HOLD);
                low_run = 0;
            end
        end
    end

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            refresh_tick = 1'b1; @(negedge clk);
            refresh_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        started = 1;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(ras_n && cas_n && !sleep_ack && !strobe_own, "R1",
              {ras_n, cas_n, sleep_ack, strobe_own}, 4'b1100);

        // R2: request refused with empty coverage
        sleep_req = 1'b1; idle_cycles(30);
        check(!strobe_own, "R2", strobe_own, 0);
        sleep_req = 1'b0;

        // R2: one short of full coverage
        ticks(ROWS - 1);
        sleep_req = 1'b1; idle_cycles(30);
        check(!strobe_own, "R2", strobe_own, 0);
        sleep_req = 1'b0;
        ticks(1);
        sleep_req = 1'b1; idle_cycles(3);
        // R3: guard refresh starts
        check(strobe_own, "R3", strobe_own, 1);

        // R4: steady sleep, ticks ignored (R8)
        wait (sleep_ack);
        @(negedge clk);
        ticks(10);
        idle_cycles(HOLD + 100);
        check(sleep_ack && !ras_n, "R4", sleep_ack, 1);
        sleep_req = 1'b0;
        wait (!sleep_ack);
        @(negedge clk);
        // R6: column strobe rises first
        check(cas_n && !ras_n, "R6", {ras_n, cas_n}, 2'b01);
        idle_cycles(2);
        check(last_ack >= HOLD, "R4", last_ack, HOLD);
        wait (!strobe_own);
        idle_cycles(2);

        // R8: coverage restarts at one after exit
        ticks(ROWS - 2);
        sleep_req = 1'b1; idle_cycles(30);
        check(!strobe_own, "R8", strobe_own, 0);
        sleep_req = 1'b0;
        ticks(1);
        sleep_req = 1'b1;
        wait (sleep_ack);
        // R5: short wake inside the hold
        idle_cycles(5);
        sleep_req = 1'b0; idle_cycles(5);
        sleep_req = 1'b1;
        wait (!sleep_ack);
        idle_cycles(3);
        check(last_ack == HOLD, "R5", last_ack, HOLD);
        wait (!strobe_own);
        idle_cycles(2);
        sleep_req = 1'b0;
        // R7: back in idle after post-exit guard
        check(ras_n && cas_n && !strobe_own, "R7", {ras_n, cas_n, strobe_own}, 3'b110);
        idle_cycles(5);
        finish_run();
    end

    initial begin
        wait (cycles > 150000);
        check(0, "watchdog", cycles, 150000);
        finish_run();
    end
endmodule